// File: doc/BRIEF.md
# Duplicated Prefetch Address Tag Store

This block keeps the address tags of a small set of prefetch buffers. Every buffer holds its tag twice, as a primary copy and a duplicate copy. A fill load writes the address bits above the line offset into both copies and marks the buffer valid. The block compares the two copies of every valid buffer all the time. When they differ, it raises a tag error and wipes the whole store.

Two 32-bit diagnostic registers show the primary and the duplicate tag of one buffer. The buffer is picked by a select input. Reads work in every mode. A write lands only when the access is privileged and the diagnostic key and mode inputs hold the unlock pair. Software uses this to plant a mismatch and check that the error path works. When the store leaves the diagnostic mode, it is cleared.

Top module: `dtag_store`

## Requirements
- R1: After reset every primary and duplicate tag reads zero and `tag_err_o` is low.
- R2: Register offset 0x28 returns the primary tag of the buffer chosen by `diag_sel_i`, and 0x2C returns its duplicate. The tag sits in bits 31:5, and bits 4:0 read zero. Any other offset reads zero.
- R3: A register write changes a tag only when `reg_priv_i`=1, `diag_key_i`=5 and `diag_mode_i`=5. Any other write leaves the tags unchanged. Write data bits 4:0 are ignored.
- R4: A fill load stores `fill_addr_i[31:5]` into both copies of buffer `fill_idx_i` and sets that buffer's valid flag. The load is suppressed when the key is not 5, or when the mode is 0 or 7.
- R5: Reads return the stored tags whatever the privilege level, key and mode are.
- R6: A valid buffer whose two copies differ drives `tag_err_o` high for exactly one cycle.
- R7: A tag error clears every tag and every valid flag on the next clock edge.
- R8: At the clock edge where the mode moves from 5 to any other value, every tag and every valid flag is cleared.
- R9: When a register write and a fill load hit the same buffer in one cycle, the written copy takes the write data and the other copy takes the fill tag.
- R10: A register write to a buffer that is not valid changes only the addressed copy and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_idx_i | input | 2 | Buffer index of the fill load |
| fill_addr_i | input | 32 | Fill address; bits 31:5 form the tag |
| fill_load_i | input | 1 | Fill load strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_priv_i | input | 1 | Access is privileged |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| diag_key_i | input | 4 | Diagnostic enable key |
| diag_mode_i | input | 3 | Diagnostic mode |
| diag_sel_i | input | 2 | Buffer shown by the diagnostic registers |
| tag_err_o | output | 1 | Address tag error pulse |

## Verification
Two pairs of events can share a cycle. A fill load and a diagnostic write can target the same buffer, and a mismatch-triggered clear can follow a write. The bench drives a fill and a primary-copy write into buffer 2 in the same cycle. It then checks that the primary copy reads the write data and that an error pulse follows, which shows the duplicate took the fill tag. Separately, it plants a mismatch in a filled buffer by a write. It checks for one error cycle and then for a store that reads empty.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  localparam int unsigned KEY_W      = 4;
  localparam int unsigned MODE_W     = 3;
  localparam int unsigned DIAG_KEY   = 5;
  localparam int unsigned MODE_DIAG  = 5;
  localparam int unsigned MODE_OFF   = 0;
  localparam int unsigned MODE_LOCK  = 7;
  localparam int unsigned OFS_PRIM   = 'h28;
  localparam int unsigned OFS_DUP    = 'h2C;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_PRIM = 2'd1,
    RSEL_DUP  = 2'd2
  } rsel_e;
endpackage

// File: rtl/dtag_ctrl.sv
module dtag_ctrl
  import dtag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              priv_i,
  output logic              fill_en_o,
  output logic              wr_en_o,
  output logic              leave_o
);
  logic [MODE_W-1:0] mode_q;
  logic              key_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_i;
  end

  assign key_ok    = (key_i == KEY_W'(DIAG_KEY));
  assign fill_en_o = key_ok && (mode_i != MODE_W'(MODE_OFF)) && (mode_i != MODE_W'(MODE_LOCK));
  assign wr_en_o   = key_ok && priv_i && (mode_i == MODE_W'(MODE_DIAG));
  assign leave_o   = (mode_q == MODE_W'(MODE_DIAG)) && (mode_i != MODE_W'(MODE_DIAG));

  // R8: leaving diagnostic mode is a single-cycle event
  a_r8_leave_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leave_o |=> !leave_o);
endmodule

// File: rtl/dtag_entry.sv
module dtag_entry #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             wr_prim_i,
  input  logic             wr_dup_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic [TAG_W-1:0] prim_o,
  output logic [TAG_W-1:0] dup_o,
  output logic             valid_o,
  output logic             mism_o
);
  logic [TAG_W-1:0] prim_q, dup_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q  <= '0;
      dup_q   <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      prim_q  <= '0;
      dup_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      // register write overrides a fill on the same copy
      if (wr_prim_i)   prim_q <= wr_tag_i;
      else if (fill_i) prim_q <= fill_tag_i;
      if (wr_dup_i)    dup_q  <= wr_tag_i;
      else if (fill_i) dup_q  <= fill_tag_i;
      if (fill_i)      valid_q <= 1'b1;
    end
  end

  assign prim_o  = prim_q;
  assign dup_o   = dup_q;
  assign valid_o = valid_q;
  assign mism_o  = valid_q && (prim_q != dup_q);

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (prim_o == '0) && (dup_o == '0) && !valid_o);

  a_r9_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prim_i && fill_i && !clr_i) |=> (prim_o == $past(wr_tag_i)));

  a_r3_prim_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || fill_i || wr_prim_i) |=> $stable(prim_o));
endmodule

// File: rtl/dtag_regif.sv
module dtag_regif
  import dtag_pkg::*;
#(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned AW      = 8,
  localparam int unsigned SEL_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned LSB    = DATA_W - TAG_W
) (
  input  logic [AW-1:0]                  addr_i,
  input  logic                           wr_i,
  input  logic                           wr_en_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [NUM_BUF-1:0][TAG_W-1:0]  prim_i,
  input  logic [NUM_BUF-1:0][TAG_W-1:0]  dup_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_BUF-1:0]             wr_prim_o,
  output logic [NUM_BUF-1:0]             wr_dup_o,
  output logic [TAG_W-1:0]               wr_tag_o
);
  rsel_e rsel;
  logic  unused_wdata_lsb;

  always_comb begin
    if (addr_i == AW'(OFS_PRIM))     rsel = RSEL_PRIM;
    else if (addr_i == AW'(OFS_DUP)) rsel = RSEL_DUP;
    else                             rsel = RSEL_NONE;
  end

  always_comb begin
    case (rsel)
      RSEL_PRIM: rdata_o = {prim_i[sel_i], {LSB{1'b0}}};
      RSEL_DUP:  rdata_o = {dup_i[sel_i],  {LSB{1'b0}}};
      default:   rdata_o = '0;
    endcase
  end

  assign wr_tag_o         = wdata_i[DATA_W-1:LSB];
  assign unused_wdata_lsb = ^wdata_i[LSB-1:0];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_wdec
    assign wr_prim_o[g] = wr_i && wr_en_i && (rsel == RSEL_PRIM) && (sel_i == SEL_W'(g));
    assign wr_dup_o[g]  = wr_i && wr_en_i && (rsel == RSEL_DUP)  && (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/dtag_store.sv
module dtag_store
  import dtag_pkg::*;
#(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned REG_AW  = 8,
  localparam int unsigned SEL_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned LSB    = ADDR_W - TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  fill_idx_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              fill_load_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              reg_priv_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic [KEY_W-1:0]  diag_key_i,
  input  logic [MODE_W-1:0] diag_mode_i,
  input  logic [SEL_W-1:0]  diag_sel_i,
  output logic              tag_err_o
);
  logic                          fill_en, wr_en, leave, clr;
  logic [NUM_BUF-1:0][TAG_W-1:0] prim, dup;
  logic [NUM_BUF-1:0]            valid, mism, wr_prim, wr_dup;
  logic [TAG_W-1:0]              wr_tag;
  logic [TAG_W-1:0]              fill_tag;
  logic                          unused_fill_lsb;

  assign fill_tag        = fill_addr_i[ADDR_W-1:LSB];
  assign unused_fill_lsb = ^fill_addr_i[LSB-1:0];

  dtag_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_i     (diag_key_i),
    .mode_i    (diag_mode_i),
    .priv_i    (reg_priv_i),
    .fill_en_o (fill_en),
    .wr_en_o   (wr_en),
    .leave_o   (leave)
  );

  dtag_regif #(
    .NUM_BUF (NUM_BUF),
    .TAG_W   (TAG_W),
    .DATA_W  (ADDR_W),
    .AW      (REG_AW)
  ) u_regif (
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .wr_en_i   (wr_en),
    .wdata_i   (reg_wdata_i),
    .sel_i     (diag_sel_i),
    .prim_i    (prim),
    .dup_i     (dup),
    .rdata_o   (reg_rdata_o),
    .wr_prim_o (wr_prim),
    .wr_dup_o  (wr_dup),
    .wr_tag_o  (wr_tag)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic fill_hit;
    assign fill_hit = fill_load_i && fill_en && (fill_idx_i == SEL_W'(g));
    dtag_entry #(.TAG_W(TAG_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .fill_i     (fill_hit),
      .fill_tag_i (fill_tag),
      .wr_prim_i  (wr_prim[g]),
      .wr_dup_i   (wr_dup[g]),
      .wr_tag_i   (wr_tag),
      .prim_o     (prim[g]),
      .dup_o      (dup[g]),
      .valid_o    (valid[g]),
      .mism_o     (mism[g])
    );
  end

  assign tag_err_o = |mism;
  assign clr       = tag_err_o || leave;

  a_r6_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o |=> !tag_err_o);

  a_r7_err_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o |=> (valid == '0));
endmodule

// File: tb/dtag_store_tb_top.sv
module dtag_store_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fill_idx_i = '0;
  logic [31:0] fill_addr_i = '0;
  logic        fill_load_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_priv_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  diag_key_i = '0;
  logic [2:0]  diag_mode_i = '0;
  logic [1:0]  diag_sel_i = '0;
  logic        tag_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  dtag_store dut_i (.*);

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] ofs, input logic [1:0] sel, output logic [31:0] v);
    reg_addr_i = ofs;
    diag_sel_i = sel;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic fill(input logic [1:0] idx, input logic [31:0] a);
    fill_idx_i = idx; fill_addr_i = a; fill_load_i = 1'b1;
    cyc();
    fill_load_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [1:0] sel, input logic [31:0] d);
    reg_addr_i = ofs; diag_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1;
    cyc();
    reg_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(8'h28, 2'(i), v); chk("R1 prim reset", v, 32'h0);
      rd(8'h2C, 2'(i), v); chk("R1 dup reset", v, 32'h0);
    end
    chk("R1 err reset", 32'(tag_err_o), 32'h0);
  endtask

  task automatic t_fill_gate();
    logic [31:0] v;
    diag_key_i = 4'd0; diag_mode_i = 3'd2;
    fill(2'd2, 32'h1234_5678);
    rd(8'h28, 2'd2, v); chk("R4 fill blocked key", v, 32'h0);
    diag_key_i = 4'd5; diag_mode_i = 3'd0;
    fill(2'd2, 32'h1234_5678);
    rd(8'h28, 2'd2, v); chk("R4 fill blocked mode0", v, 32'h0);
    diag_mode_i = 3'd7;
    fill(2'd2, 32'h1234_5678);
    rd(8'h2C, 2'd2, v); chk("R4 fill blocked mode7", v, 32'h0);
    diag_mode_i = 3'd3;
    fill(2'd0, 32'h8765_4321);
    rd(8'h28, 2'd0, v); chk("R4 fill prim", v, 32'h8765_4320);
    rd(8'h2C, 2'd0, v); chk("R4 fill dup", v, 32'h8765_4320);
    rd(8'h30, 2'd0, v); chk("R2 other offset", v, 32'h0);
    chk("R4 no err", 32'(tag_err_o), 32'h0);
  endtask

  task automatic t_wr_gate();
    logic [31:0] v;
    reg_priv_i = 1'b1;
    wr(8'h28, 2'd0, 32'h0);
    rd(8'h28, 2'd0, v); chk("R3 blocked mode3", v, 32'h8765_4320);
    diag_mode_i = 3'd5;
    reg_priv_i = 1'b0;
    wr(8'h28, 2'd0, 32'h0);
    rd(8'h28, 2'd0, v); chk("R3 blocked unpriv", v, 32'h8765_4320);
    reg_priv_i = 1'b1; diag_key_i = 4'd4;
    wr(8'h28, 2'd0, 32'h0);
    rd(8'h28, 2'd0, v); chk("R3 blocked key", v, 32'h8765_4320);
    diag_key_i = 4'd5;
    wr(8'h2C, 2'd3, 32'hFFFF_FFFF);
    rd(8'h2C, 2'd3, v); chk("R3 write dup masked", v, 32'hFFFF_FFE0);
    rd(8'h28, 2'd3, v); chk("R10 prim untouched", v, 32'h0);
    chk("R10 no err invalid buf", 32'(tag_err_o), 32'h0);
    reg_priv_i = 1'b0; diag_key_i = 4'd2;
    rd(8'h2C, 2'd3, v); chk("R5 read unpriv", v, 32'hFFFF_FFE0);
    diag_key_i = 4'd5; reg_priv_i = 1'b1;
  endtask

  task automatic t_inject();
    logic [31:0] v;
    fill(2'd1, 32'hABCD_EF1F);
    rd(8'h28, 2'd1, v); chk("R4 fill mode5", v, 32'hABCD_EF00);
    wr(8'h2C, 2'd1, 32'h1111_1100);
    chk("R6 err raised", 32'(tag_err_o), 32'h1);
    cyc();
    chk("R6 err one cycle", 32'(tag_err_o), 32'h0);
    rd(8'h28, 2'd0, v); chk("R7 buf0 cleared", v, 32'h0);
    rd(8'h2C, 2'd3, v); chk("R7 buf3 cleared", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    fill_idx_i = 2'd2; fill_addr_i = 32'h4000_0000; fill_load_i = 1'b1;
    reg_addr_i = 8'h28; diag_sel_i = 2'd2; reg_wdata_i = 32'h0BAD_0000; reg_wr_i = 1'b1;
    cyc();
    fill_load_i = 1'b0; reg_wr_i = 1'b0;
    rd(8'h28, 2'd2, v); chk("R9 write wins prim", v, 32'h0BAD_0000);
    chk("R9 dup took fill", 32'(tag_err_o), 32'h1);
    cyc();
    rd(8'h2C, 2'd2, v); chk("R7 cleared after collide", v, 32'h0);
  endtask

  task automatic t_leave();
    logic [31:0] v;
    fill(2'd3, 32'h5555_5540);
    rd(8'h28, 2'd3, v); chk("R4 fill buf3", v, 32'h5555_5540);
    diag_mode_i = 3'd4;
    cyc();
    rd(8'h28, 2'd3, v); chk("R8 leave clears prim", v, 32'h0);
    rd(8'h2C, 2'd3, v); chk("R8 leave clears dup", v, 32'h0);
    chk("R8 no err", 32'(tag_err_o), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill_gate();
    t_wr_gate();
    t_inject();
    t_collide();
    t_leave();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule